// File: doc/BRIEF.md
# Register-Programmed Block Copy Engine

This block copies a run of bytes between a private byte buffer and an external host memory. Software loads a source address, a destination address and a byte count into 64-bit registers and then writes a command word whose low bit starts the job. One side of every copy is the private buffer, which the engine sees at a fixed window beginning at address 0x40000. The other side is the host memory, reached through a request/acknowledge port that moves one byte per beat.

A started job does not move data at once. It first waits a programmable number of clock ticks. The engine then checks that the buffer-side range fits inside the window. It masks the host-side address to 28 bits and copies the bytes in ascending order. At the end it clears the run bit, and it can raise the completion cause toward the interrupt controller. While the run bit is set, the engine owns its registers and the buffer, and it ignores writes to them from outside. The buffer can also be loaded and read through a byte-wide window port when the engine is idle.

Top module: `blkdma_engine`

## Requirements
- R1: After reset, all four registers read 0, no host request is active, the error flag is 0 and the interrupt cause output is 0.
- R2: While idle, writes with reg_sel 0 (source), 1 (destination) and 2 (count) store the 64-bit value, and the same select reads it back on reg_rdata.
- R3: A write to the command register (reg_sel 3) whose bit 0 is 0 is discarded: the command register keeps its old value and no job starts.
- R4: While command bit 0 (run) is set, writes to all four registers and writes through the buffer window port have no effect.
- R5: The first host request appears DELAY_TICKS+1 clock edges after the edge that accepts a command write with bit 0 set.
- R6: With command bit 1 = 0, byte i is read from host address (source & 0x0FFFFFFF) + i and stored in the buffer at (destination - 0x40000) + i, for i from 0 to count-1.
- R7: With command bit 1 = 1, the buffer byte at (source - 0x40000) + i is written to host address (destination & 0x0FFFFFFF) + i, for i from 0 to count-1.
- R8: A buffer-side range [a, a+count) is accepted only if a >= 0x40000 and a+count, computed without wrap, is at most 0x40000 + BUF_BYTES. Otherwise the job aborts with no host request and no buffer change. The run bit clears and err_flag goes to 1 and stays there until the next accepted command with bit 0 set.
- R9: When a job completes, command bit 0 clears and the other command bits keep their values. If command bit 2 is set, irq_set carries 0x100 for exactly one cycle. If bit 2 is clear, irq_set stays 0.
- R10: A count of 0 completes after the delay without any host request or range check and without setting err_flag.
- R11: Host address bits above bit 27 of the source or destination register never reach hst_addr. hst_addr is 28 bits wide and is formed from the masked address plus the byte index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 command |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Contents of the selected register |
| win_we | input | 1 | Buffer window write strobe (ignored while running) |
| win_off | input | $clog2(BUF_BYTES) | Byte offset into the buffer |
| win_wdata | input | 8 | Buffer window write data |
| win_rdata | output | 8 | Buffer byte at win_off |
| hst_req | output | 1 | Host beat request, held until acknowledged |
| hst_we | output | 1 | 1 = host write beat, 0 = host read beat |
| hst_addr | output | 28 | Host byte address |
| hst_wdata | output | 8 | Host write data |
| hst_ack | input | 1 | Host beat acknowledge |
| hst_rdata | input | 8 | Host read data, valid with hst_ack |
| err_flag | output | 1 | Sticky range-fault flag |
| irq_set | output | 32 | Interrupt cause, 0x100 pulse on completion |

## Verification
Several properties are checked on every cycle. Register contents hold while the run bit is set. A discarded command write leaves the command unchanged. Host requests occur only while a job runs. The buffer is never written while a fault is flagged. A fault clears the run bit without a request, and the run bit is low in the cycle after a completion pulse. The bench scenarios show the rest: the exact start delay, the byte-for-byte contents in both directions over a sweep of offsets and lengths, the edges of the window check, including an exact fit and an overflowing count, the zero-count case and the masking of host addresses.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int          REG_W     = 64;
    localparam int          HOST_AW   = 28;
    localparam logic [63:0] HOST_MASK = (64'd1 << HOST_AW) - 64'd1;
    localparam logic [63:0] WIN_BASE  = 64'h0000_0000_0004_0000;
    localparam logic [31:0] IRQ_DONE  = 32'h0000_0100;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CMD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [60:0] spare;
        logic        irq_en;
        logic        to_host;
        logic        run;
    } cmd_t;

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] cnt;
        cmd_t             cmd;
    } regs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CHECK,
        ST_XFER,
        ST_DONE
    } seq_st_e;

    // Range [a, a+n) must sit inside [base, base+size); sums kept at 65 bits.
    function automatic logic range_ok(input logic [63:0] a, input logic [63:0] n,
                                      input logic [63:0] base, input logic [63:0] size);
        logic [64:0] end_a;
        logic [64:0] end_w;
        end_a = {1'b0, a} + {1'b0, n};
        end_w = {1'b0, base} + {1'b0, size};
        return (a >= base) && (end_a <= end_w);
    endfunction

    function automatic logic [HOST_AW-1:0] host_mask(input logic [63:0] a);
        logic [63:0] m;
        m = a & HOST_MASK;
        return m[HOST_AW-1:0];
    endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  reg_sel_e    sel,
    input  logic [63:0] wdata,
    input  logic        run_clr,
    output regs_t       regs,
    output logic        start,
    output logic [63:0] rdata
);
    regs_t regs_q;
    logic  busy;

    assign busy  = regs_q.cmd.run;
    assign start = we && !busy && (sel == SEL_CMD) && wdata[0];
    assign regs  = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (run_clr) begin
            regs_q.cmd.run <= 1'b0;
        end else if (we && !busy) begin
            case (sel)
                SEL_SRC: regs_q.src <= wdata;
                SEL_DST: regs_q.dst <= wdata;
                SEL_CNT: regs_q.cnt <= wdata;
                SEL_CMD: if (wdata[0]) regs_q.cmd <= cmd_t'(wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_SRC: rdata = regs_q.src;
            SEL_DST: rdata = regs_q.dst;
            SEL_CNT: rdata = regs_q.cnt;
            default: rdata = regs_q.cmd;
        endcase
    end

    // R4: address and count registers frozen while a job runs
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && we) |=> ($stable(regs_q.src) && $stable(regs_q.dst) && $stable(regs_q.cnt)));

    // R3: a command write without the run bit leaves the command untouched
    assert_drop_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && we && sel == SEL_CMD && !wdata[0]) |=> $stable(regs_q.cmd));

endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
    import blkdma_pkg::*;
#(
    parameter int BUF_BYTES   = 4096,
    parameter int DELAY_TICKS = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  regs_t                         regs,
    input  logic                          hst_ack,
    input  logic [7:0]                    hst_rdata,
    input  logic [7:0]                    buf_rdata,
    output logic                          hst_req,
    output logic                          hst_we,
    output logic [HOST_AW-1:0]            hst_addr,
    output logic [7:0]                    hst_wdata,
    output logic                          buf_we,
    output logic [$clog2(BUF_BYTES)-1:0]  buf_idx,
    output logic [7:0]                    buf_wdata,
    output logic                          run_clr,
    output logic                          err_flag,
    output logic [31:0]                   irq_set
);
    localparam int BUF_AW = $clog2(BUF_BYTES);
    localparam int IDX_W  = BUF_AW + 1;
    localparam int DLY_W  = $clog2(DELAY_TICKS) + 1;

    seq_st_e          state;
    logic [DLY_W-1:0] wcnt;
    logic [IDX_W-1:0] idx;
    logic [63:0]      buf_base;
    logic [63:0]      host_base;
    logic [63:0]      buf_off;
    logic             fits;
    logic             cnt_zero;
    logic             last;

    assign buf_base  = regs.cmd.to_host ? regs.src : regs.dst;
    assign host_base = regs.cmd.to_host ? regs.dst : regs.src;
    assign buf_off   = buf_base - WIN_BASE;
    assign fits      = range_ok(buf_base, regs.cnt, WIN_BASE, 64'(BUF_BYTES));
    assign cnt_zero  = (regs.cnt == 64'd0);
    assign last      = (idx == regs.cnt[IDX_W-1:0] - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            idx      <= '0;
            err_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_WAIT;
                    wcnt     <= '0;
                    err_flag <= 1'b0;
                end
                ST_WAIT: begin
                    if (wcnt == DLY_W'(DELAY_TICKS - 1)) state <= ST_CHECK;
                    else                                 wcnt  <= wcnt + DLY_W'(1);
                end
                ST_CHECK: begin
                    idx <= '0;
                    if (cnt_zero)   state <= ST_DONE;
                    else if (!fits) begin
                        state    <= ST_IDLE;
                        err_flag <= 1'b1;
                    end else        state <= ST_XFER;
                end
                ST_XFER: if (hst_ack) begin
                    if (last) state <= ST_DONE;
                    else      idx   <= idx + IDX_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run_clr   = (state == ST_DONE) || (state == ST_CHECK && !cnt_zero && !fits);
    assign irq_set   = (state == ST_DONE && regs.cmd.irq_en) ? IRQ_DONE : 32'd0;
    assign hst_req   = (state == ST_XFER);
    assign hst_we    = regs.cmd.to_host;
    assign hst_addr  = host_mask(host_base) + HOST_AW'(idx);
    assign hst_wdata = buf_rdata;
    assign buf_idx   = buf_off[BUF_AW-1:0] + idx[BUF_AW-1:0];
    assign buf_we    = (state == ST_XFER) && hst_ack && !regs.cmd.to_host;
    assign buf_wdata = hst_rdata;

    // R8: host beats only happen inside a running job
    assert_req_in_run_R8: assert property (@(posedge clk) disable iff (rst)
        hst_req |-> regs.cmd.run);

    // R8: the buffer is never written while a fault is flagged
    assert_no_write_on_fault_R8: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> !err_flag);

    // R8: a fault ends the job with no request pending
    assert_fault_stops_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> (!hst_req && !regs.cmd.run));

    // R9: the completion pulse is followed by a cleared run bit
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_set != 32'd0) |=> !regs.cmd.run);

    // R9: only the completion cause is ever signalled
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_set != 32'd0) |-> ($countones(irq_set) == 1 && irq_set[8] && regs.cmd.irq_en));

endmodule

// File: rtl/blkdma_buf.sv
module blkdma_buf #(
    parameter int BUF_BYTES = 4096
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(BUF_BYTES)-1:0] waddr,
    input  logic [7:0]                   wdata,
    input  logic [$clog2(BUF_BYTES)-1:0] raddr_a,
    output logic [7:0]                   rdata_a,
    input  logic [$clog2(BUF_BYTES)-1:0] raddr_b,
    output logic [7:0]                   rdata_b
);
    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int BUF_BYTES   = 4096,
    parameter int DELAY_TICKS = 100
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [1:0]                   reg_sel,
    input  logic [63:0]                  reg_wdata,
    output logic [63:0]                  reg_rdata,
    input  logic                         win_we,
    input  logic [$clog2(BUF_BYTES)-1:0] win_off,
    input  logic [7:0]                   win_wdata,
    output logic [7:0]                   win_rdata,
    output logic                         hst_req,
    output logic                         hst_we,
    output logic [27:0]                  hst_addr,
    output logic [7:0]                   hst_wdata,
    input  logic                         hst_ack,
    input  logic [7:0]                   hst_rdata,
    output logic                         err_flag,
    output logic [31:0]                  irq_set
);
    localparam int BUF_AW = $clog2(BUF_BYTES);

    regs_t             regs;
    logic              start;
    logic              run_clr;
    logic              eng_we;
    logic [BUF_AW-1:0] eng_idx;
    logic [7:0]        eng_wdata;
    logic [7:0]        eng_rdata;
    logic              ram_we;
    logic [BUF_AW-1:0] ram_waddr;
    logic [7:0]        ram_wdata;

    blkdma_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .sel     (reg_sel_e'(reg_sel)),
        .wdata   (reg_wdata),
        .run_clr (run_clr),
        .regs    (regs),
        .start   (start),
        .rdata   (reg_rdata)
    );

    blkdma_seq #(
        .BUF_BYTES   (BUF_BYTES),
        .DELAY_TICKS (DELAY_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .regs      (regs),
        .hst_ack   (hst_ack),
        .hst_rdata (hst_rdata),
        .buf_rdata (eng_rdata),
        .hst_req   (hst_req),
        .hst_we    (hst_we),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .buf_we    (eng_we),
        .buf_idx   (eng_idx),
        .buf_wdata (eng_wdata),
        .run_clr   (run_clr),
        .err_flag  (err_flag),
        .irq_set   (irq_set)
    );

    // Engine owns the write port while a job runs; the window writes only when idle.
    assign ram_we    = eng_we || (win_we && !regs.cmd.run);
    assign ram_waddr = eng_we ? eng_idx   : win_off;
    assign ram_wdata = eng_we ? eng_wdata : win_wdata;

    blkdma_buf #(
        .BUF_BYTES (BUF_BYTES)
    ) u_buf (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (eng_idx),
        .rdata_a (eng_rdata),
        .raddr_b (win_off),
        .rdata_b (win_rdata)
    );

endmodule

// File: tb/sim_blkdma_engine.sv
module sim_blkdma_engine;
    localparam int          BB  = 64;
    localparam int          DT  = 6;
    localparam int          AW  = $clog2(BB);
    localparam logic [63:0] WIN = 64'h4_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          win_we = 1'b0;
    logic [AW-1:0] win_off = '0;
    logic [7:0]    win_wdata = '0;
    logic [7:0]    win_rdata;
    logic          hst_req, hst_we;
    logic [27:0]   hst_addr;
    logic [7:0]    hst_wdata;
    logic          hst_ack = 1'b0;
    logic [7:0]    hst_rdata = '0;
    logic          err_flag;
    logic [31:0]   irq_set;

    int checks = 0;
    int fails  = 0;
    int acks   = 0;
    int irq_cnt = 0;
    int irq_bad = 0;
    int hi_bad  = 0;
    int rcnt    = 0;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_buf [BB];

    always #10 clk = ~clk;

    blkdma_engine #(.BUF_BYTES(BB), .DELAY_TICKS(DT)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .win_we(win_we), .win_off(win_off), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .err_flag(err_flag), .irq_set(irq_set)
    );

    // Host memory: acknowledges a held request on its second cycle.
    always @(posedge clk) begin
        if (hst_req && !hst_ack) begin
            if (rcnt == 1) begin
                hst_ack   <= 1'b1;
                hst_rdata <= mem[hst_addr[7:0]];
                if (hst_we) mem[hst_addr[7:0]] <= hst_wdata;
                if (hst_addr[27:8] != 20'd0) hi_bad <= hi_bad + 1;
                acks <= acks + 1;
                rcnt <= 0;
            end else rcnt <= rcnt + 1;
        end else begin
            hst_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst && irq_set != 32'd0) begin
            irq_cnt <= irq_cnt + 1;
            if (irq_set != 32'h100) irq_bad <= irq_bad + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic win_wr(input int off, input logic [7:0] d);
        @(negedge clk);
        win_we = 1'b1; win_off = AW'(off); win_wdata = d;
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic win_rd(input int off, output logic [7:0] d);
        win_off = AW'(off);
        #1 d = win_rdata;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        reg_sel = 2'd3;
        #1;
        while (reg_rdata[0] && n < 3000) begin
            @(negedge clk);
            reg_sel = 2'd3;
            #1;
            n++;
        end
        if (n >= 3000) check(1'b0, "watchdog job never finished", 64'(n), 64'd0);
    endtask

    task automatic cmp_buf(input string req);
        logic [7:0] v;
        int bad;
        logic [7:0] a, e;
        bad = 0; a = 0; e = 0;
        @(negedge clk);
        for (int i = 0; i < BB; i++) begin
            win_rd(i, v);
            if (v !== exp_buf[i] && bad == 0) begin a = v; e = exp_buf[i]; end
            if (v !== exp_buf[i]) bad++;
        end
        check(bad == 0, req, 64'(a), 64'(e));
    endtask

    task automatic cmp_mem(input string req);
        int bad;
        logic [7:0] a, e;
        bad = 0; a = 0; e = 0;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== exp_mem[i] && bad == 0) begin a = mem[i]; e = exp_mem[i]; end
            if (mem[i] !== exp_mem[i]) bad++;
        end
        check(bad == 0, req, 64'(a), 64'(e));
    endtask

    // Start a job, measure the start delay, wait for the end.
    task automatic run_job(input logic [63:0] src, input logic [63:0] dst,
                           input logic [63:0] cnt, input logic [63:0] cmd, output int dly);
        int n;
        wr(2'd0, src);
        wr(2'd1, dst);
        wr(2'd2, cnt);
        wr(2'd3, cmd);
        n = 0;
        while (!hst_req && reg_rdata[0] && n < 1000) begin
            @(negedge clk);
            reg_sel = 2'd3;
            #1;
            n++;
        end
        dly = hst_req ? n : -1;
        wait_idle();
    endtask

    initial begin
        logic [63:0] r;
        logic [7:0]  b;
        int dly, i0, ic0;
        int offs[4] = '{0, 1, 13, 40};
        int lens[3] = '{1, 2, 7};
        int job;

        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), r);
            check(r == 64'd0, "R1 register reset value", r, 64'd0);
        end
        check(!hst_req && !err_flag && irq_set == 32'd0, "R1 outputs idle after reset",
              {31'd0, hst_req, err_flag, irq_set}, 64'd0);

        // R2: register write and read back while idle
        wr(2'd0, 64'h1234_5678_9ABC_DEF0); rd(2'd0, r);
        check(r == 64'h1234_5678_9ABC_DEF0, "R2 source readback", r, 64'h1234_5678_9ABC_DEF0);
        wr(2'd1, 64'hFEDC_BA98_7654_3210); rd(2'd1, r);
        check(r == 64'hFEDC_BA98_7654_3210, "R2 destination readback", r, 64'hFEDC_BA98_7654_3210);
        wr(2'd2, 64'h0000_0000_0000_0031); rd(2'd2, r);
        check(r == 64'h31, "R2 count readback", r, 64'h31);

        // R3: command write with bit 0 clear is dropped
        wr(2'd3, 64'h0000_0000_0000_0006); rd(2'd3, r);
        check(r == 64'd0, "R3 dropped command write", r, 64'd0);
        repeat (DT + 4) @(negedge clk);
        check(acks == 0, "R3 no job after dropped command", 64'(acks), 64'd0);

        // Buffer preload through the window
        for (int i = 0; i < BB; i++) begin
            exp_buf[i] = 8'hA0 ^ 8'(i);
            win_wr(i, exp_buf[i]);
        end
        cmp_buf("R4 window preload while idle");

        // R6/R5/R9/R11: host -> buffer sweep, high host address bits set
        job = 0;
        foreach (offs[k]) begin
            foreach (lens[m]) begin
                int h;
                logic [63:0] cmd;
                h   = 16 * job + 5;
                cmd = (job % 2 == 0) ? 64'h5 : 64'h1;
                ic0 = irq_cnt;
                run_job(64'hFFFF_FFF0_0000_0000 | 64'(h), WIN + 64'(offs[k]),
                        64'(lens[m]), cmd, dly);
                check(dly == DT + 1, "R5 start delay", 64'(dly), 64'(DT + 1));
                for (int j = 0; j < lens[m]; j++) exp_buf[offs[k] + j] = mem[(h + j) % 256];
                cmp_buf("R6 host to buffer contents");
                check(irq_cnt - ic0 == ((job % 2 == 0) ? 1 : 0), "R9 completion pulse count",
                      64'(irq_cnt - ic0), 64'((job % 2 == 0) ? 1 : 0));
                rd(2'd3, r);
                check(r == (cmd & ~64'd1), "R9 run bit cleared, others kept", r, cmd & ~64'd1);
                check(!err_flag, "R6 no error on valid range", 64'(err_flag), 64'd0);
                job++;
            end
        end

        // R7: buffer -> host sweep
        for (int k = 0; k < 4; k++) begin
            int h, off, n;
            h = 128 + 24 * k; off = 9 * k + 2; n = 3 + 4 * k;
            run_job(WIN + 64'(off), 64'hABC0_0000_0000_0000 | 64'(h), 64'(n), 64'h3, dly);
            check(dly == DT + 1, "R5 start delay buffer to host", 64'(dly), 64'(DT + 1));
            for (int j = 0; j < n; j++) exp_mem[h + j] = exp_buf[off + j];
            cmp_mem("R7 buffer to host contents");
        end

        // R11: no host address bit above 27 survived
        check(hi_bad == 0, "R11 host address masked", 64'(hi_bad), 64'd0);

        // R8: range faults
        begin
            logic [63:0] fa [4] = '{64'h3_FFFF, WIN + 64'd60, WIN + 64'(BB), WIN};
            logic [63:0] fc [4] = '{64'd1, 64'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF};
            for (int f = 0; f < 4; f++) begin
                i0 = acks; ic0 = irq_cnt;
                run_job(64'h10, fa[f], fc[f], 64'h5, dly);
                check(err_flag, "R8 fault flag set", 64'(err_flag), 64'd1);
                check(acks == i0 && dly == -1, "R8 no host beat on fault", 64'(acks - i0), 64'd0);
                check(irq_cnt == ic0, "R8 no completion pulse on fault", 64'(irq_cnt - ic0), 64'd0);
                rd(2'd3, r);
                check(r[0] == 1'b0, "R8 run cleared on fault", r, 64'h4);
                cmp_buf("R8 buffer unchanged on fault");
            end
            repeat (5) @(negedge clk);
            check(err_flag, "R8 fault flag sticky", 64'(err_flag), 64'd1);
        end

        // R8: exact fit at the top of the window succeeds and clears the flag
        run_job(64'h40, WIN + 64'(BB - 4), 64'd4, 64'h1, dly);
        for (int j = 0; j < 4; j++) exp_buf[BB - 4 + j] = mem[64 + j];
        check(!err_flag, "R8 exact fit clears flag", 64'(err_flag), 64'd0);
        cmp_buf("R8 exact fit contents");

        // R10: zero count, out-of-window address
        i0 = acks; ic0 = irq_cnt;
        run_job(64'h0, 64'h0, 64'd0, 64'h5, dly);
        check(acks == i0, "R10 no host beat for zero count", 64'(acks - i0), 64'd0);
        check(!err_flag, "R10 no fault for zero count", 64'(err_flag), 64'd0);
        check(irq_cnt == ic0 + 1, "R10 completion pulse for zero count",
              64'(irq_cnt - ic0), 64'd1);

        // R4: writes during a running job are ignored
        wr(2'd0, 64'h0);
        wr(2'd1, WIN);
        wr(2'd2, 64'd20);
        wr(2'd3, 64'h1);
        wr(2'd0, 64'h77);
        wr(2'd2, 64'd1);
        wr(2'd3, 64'h7);
        win_wr(50, 8'h5A);
        wait_idle();
        for (int j = 0; j < 20; j++) exp_buf[j] = mem[j];
        rd(2'd0, r);
        check(r == 64'h0, "R4 source write ignored while running", r, 64'h0);
        rd(2'd2, r);
        check(r == 64'd20, "R4 count write ignored while running", r, 64'd20);
        rd(2'd3, r);
        check(r == 64'h0, "R4 command write ignored while running", r, 64'h0);
        cmp_buf("R4 window write ignored while running");
        check(irq_bad == 0, "R9 cause value", 64'(irq_bad), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule